// File: doc/BRIEF.md
# Coefficient Status Flag Store

This block keeps three single-bit flags for every coefficient of a 32x32 code-block while its bit-planes are being coded. The working significance array is the view that neighbour and context calculations read during a plane. The refinement array notes that a coefficient has already had a magnitude refinement. The update array gathers coefficients that become significant during the current plane. Flags are set one coefficient at a time. Reads return a column word of four vertically adjacent coefficients, taken from all three arrays in the same cycle.

The code-block is addressed as eight stripes of four rows, with a column index of 0 to 31. Row r of the block is row r mod 4 of stripe r/4. Significance is double-buffered. A coefficient marked significant during a plane shows up at once in the update array, but the working array picks it up only when the plane-start command copies the whole update array across. A clear command zeroes all three arrays before a new code-block.

A small controller handles both commands. It has three states. ST_IDLE accepts commands. ST_COPY copies one column word per cycle from the update array into the working array. ST_CLEAR zeroes one column word per cycle in all three arrays. Its transitions are:
- ST_IDLE to ST_CLEAR when clear is requested. A clear wins over a plane start in the same cycle.
- ST_IDLE to ST_COPY when only a plane start is requested.
- ST_COPY or ST_CLEAR back to ST_IDLE once the last of the 256 words has been handled.

Top module: `coef_status_mem`

## Requirements
- R1: After reset, busy_o and rd_valid_o are 0 and every flag in all three arrays reads as 0.
- R2: A read accepted at a clock edge (rd_en_i high, busy_o low) gives rd_valid_o = 1 after that edge. The outputs then hold three 4-bit words. Bit k of each word is the flag of block row 4*rd_stripe_i + k in column rd_col_i.
- R3: A write with wr_tgt_i = 0 sets the update-array flag of row 4*wr_stripe_i + wr_row_i, column wr_col_i. The flag is visible on new_o for any read accepted afterwards. sig_o does not change until the next plane start completes.
- R4: A write with wr_tgt_i = 1 sets the refinement flag of the addressed coefficient. Writes only ever set flags, never clear them.
- R5: A plane start accepted in idle raises busy_o after that edge for exactly 256 cycles. When it finishes, the working significance array equals the update array.
- R6: While busy_o is high, reads give rd_valid_o = 0 and writes change no flag.
- R7: A clear accepted in idle raises busy_o for exactly 256 cycles. When it finishes, all three arrays read as 0.
- R8: Clear takes priority over a simultaneous plane start. Either command is ignored while busy_o is high.
- R9: When a read and a write are accepted at the same edge, the read returns the flags as they were before that write.
- R10: Every flag set in the working significance array is also set in the update array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Zero all three arrays |
| plane_start_i | input | 1 | Copy the update array into the working array |
| busy_o | output | 1 | A copy or clear sweep is running |
| rd_en_i | input | 1 | Read request |
| rd_stripe_i | input | 3 | Stripe index of the read |
| rd_col_i | input | 5 | Column index of the read |
| rd_valid_o | output | 1 | Read words are valid this cycle |
| sig_o | output | 4 | Working significance flags of the column word |
| ref_o | output | 4 | Refinement flags of the column word |
| new_o | output | 4 | Update-array flags of the column word |
| wr_en_i | input | 1 | Single-flag set request |
| wr_tgt_i | input | 1 | 0 selects the update array, 1 the refinement array |
| wr_stripe_i | input | 3 | Stripe index of the write |
| wr_col_i | input | 5 | Column index of the write |
| wr_row_i | input | 2 | Row within the stripe of the write |

## Verification
Read words are registered and appear one cycle after the edge that accepts rd_en_i. A write lands on the same edge it is accepted, so a read issued at the next edge already sees it. busy_o rises on the edge that accepts a command and falls 256 edges later. The bench therefore drives every input on the falling edge and samples on the following falling edge. It counts falling edges while busy_o is high to measure sweep length, and compares each column word against arrays modelled in the bench, sweeping every stripe and column after each phase.

// File: rtl/csm_pkg.sv
`timescale 1ns/1ps
package csm_pkg;
    localparam int CB_W_DEF     = 32;
    localparam int CB_H_DEF     = 32;
    localparam int STRIPE_H_DEF = 4;

    localparam int NBANK = 3;
    localparam int B_SIG = 0;
    localparam int B_REF = 1;
    localparam int B_NEW = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COPY  = 2'd1,
        ST_CLEAR = 2'd2
    } csm_state_e;

    typedef enum logic {
        TGT_NEW = 1'b0,
        TGT_REF = 1'b1
    } csm_tgt_e;
endpackage

// File: rtl/csm_bank.sv
`timescale 1ns/1ps
module csm_bank #(
    parameter int NWORDS = 256,
    parameter int WORD_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(NWORDS)-1:0]   rd_addr_i,
    output logic [WORD_W-1:0]           rd_word_o,
    input  logic                        set_en_i,
    input  logic [$clog2(NWORDS)-1:0]   set_addr_i,
    input  logic [$clog2(WORD_W)-1:0]   set_bit_i,
    input  logic                        word_en_i,
    input  logic [$clog2(NWORDS)-1:0]   word_addr_i,
    input  logic [WORD_W-1:0]           word_i
);
    logic [WORD_W-1:0] mem_q [NWORDS];

    assign rd_word_o = mem_q[rd_addr_i];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NWORDS; i++) begin
                mem_q[i] <= '0;
            end
        end else if (word_en_i) begin
            mem_q[word_addr_i] <= word_i;
        end else if (set_en_i) begin
            mem_q[set_addr_i][set_bit_i] <= 1'b1;
        end
    end

    // Sweeps and single-flag writes never meet (R6)
    assert_no_write_clash_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_en_i && set_en_i));
endmodule

// File: rtl/csm_ctrl.sv
`timescale 1ns/1ps
module csm_ctrl
    import csm_pkg::*;
#(
    parameter int NWORDS = 256
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      plane_start_i,
    input  logic                      clear_i,
    output logic                      busy_o,
    output logic                      sweep_en_o,
    output logic                      sweep_clear_o,
    output logic [$clog2(NWORDS)-1:0] sweep_addr_o
);
    localparam int AW = $clog2(NWORDS);
    localparam logic [AW-1:0] LAST = AW'(NWORDS - 1);

    csm_state_e    state_q, state_d;
    logic [AW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_q == ST_IDLE) ? '0 : cnt_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (clear_i)            state_d = ST_CLEAR;
                else if (plane_start_i) state_d = ST_COPY;
            end
            ST_COPY, ST_CLEAR: begin
                if (cnt_q == LAST)      state_d = ST_IDLE;
            end
            default:                    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy_o        = 1'b0;
        sweep_en_o    = 1'b0;
        sweep_clear_o = 1'b0;
        sweep_addr_o  = cnt_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_COPY: begin
                busy_o     = 1'b1;
                sweep_en_o = 1'b1;
            end
            ST_CLEAR: begin
                busy_o        = 1'b1;
                sweep_en_o    = 1'b1;
                sweep_clear_o = 1'b1;
            end
            default: ;
        endcase
    end

    assert_plane_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && plane_start_i && !clear_i) |=> state_q == ST_COPY);

    assert_clear_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && clear_i) |=> state_q == ST_CLEAR);

    assert_sweep_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && cnt_q != LAST) |=> (cnt_q == AW'($past(cnt_q) + 1'b1)));

    assert_busy_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(plane_start_i || clear_i));
endmodule

// File: rtl/coef_status_mem.sv
`timescale 1ns/1ps
module coef_status_mem
    import csm_pkg::*;
#(
    parameter  int CB_W     = CB_W_DEF,
    parameter  int CB_H     = CB_H_DEF,
    parameter  int STRIPE_H = STRIPE_H_DEF,
    localparam int NSTRIPE  = CB_H / STRIPE_H,
    localparam int SW       = $clog2(NSTRIPE),
    localparam int CW       = $clog2(CB_W),
    localparam int RW       = $clog2(STRIPE_H)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_i,
    input  logic                plane_start_i,
    output logic                busy_o,
    input  logic                rd_en_i,
    input  logic [SW-1:0]       rd_stripe_i,
    input  logic [CW-1:0]       rd_col_i,
    output logic                rd_valid_o,
    output logic [STRIPE_H-1:0] sig_o,
    output logic [STRIPE_H-1:0] ref_o,
    output logic [STRIPE_H-1:0] new_o,
    input  logic                wr_en_i,
    input  logic                wr_tgt_i,
    input  logic [SW-1:0]       wr_stripe_i,
    input  logic [CW-1:0]       wr_col_i,
    input  logic [RW-1:0]       wr_row_i
);
    localparam int NWORDS = NSTRIPE * CB_W;
    localparam int AW     = $clog2(NWORDS);

    logic          busy, sweep_en, sweep_clear;
    logic [AW-1:0] sweep_addr, rd_addr, wr_addr, port_addr;
    logic          wr_ok, rd_ok;

    logic                set_en  [NBANK];
    logic                word_en [NBANK];
    logic [STRIPE_H-1:0] word_in [NBANK];
    logic [STRIPE_H-1:0] rd_word [NBANK];

    csm_ctrl #(.NWORDS(NWORDS)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .plane_start_i(plane_start_i),
        .clear_i      (clear_i),
        .busy_o       (busy),
        .sweep_en_o   (sweep_en),
        .sweep_clear_o(sweep_clear),
        .sweep_addr_o (sweep_addr)
    );

    assign busy_o    = busy;
    assign rd_addr   = AW'(rd_stripe_i) * AW'(CB_W) + AW'(rd_col_i);
    assign wr_addr   = AW'(wr_stripe_i) * AW'(CB_W) + AW'(wr_col_i);
    assign port_addr = busy ? sweep_addr : rd_addr;
    assign wr_ok     = wr_en_i & ~busy;
    assign rd_ok     = rd_en_i & ~busy;

    always_comb begin
        set_en[B_SIG]  = 1'b0;
        set_en[B_REF]  = wr_ok & (csm_tgt_e'(wr_tgt_i) == TGT_REF);
        set_en[B_NEW]  = wr_ok & (csm_tgt_e'(wr_tgt_i) == TGT_NEW);
        word_en[B_SIG] = sweep_en;
        word_en[B_REF] = sweep_en & sweep_clear;
        word_en[B_NEW] = sweep_en & sweep_clear;
        word_in[B_SIG] = sweep_clear ? '0 : rd_word[B_NEW];
        word_in[B_REF] = '0;
        word_in[B_NEW] = '0;
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        csm_bank #(.NWORDS(NWORDS), .WORD_W(STRIPE_H)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .rd_addr_i  (port_addr),
            .rd_word_o  (rd_word[b]),
            .set_en_i   (set_en[b]),
            .set_addr_i (wr_addr),
            .set_bit_i  (wr_row_i),
            .word_en_i  (word_en[b]),
            .word_addr_i(sweep_addr),
            .word_i     (word_in[b])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid_o <= 1'b0;
            sig_o      <= '0;
            ref_o      <= '0;
            new_o      <= '0;
        end else begin
            rd_valid_o <= rd_ok;
            if (rd_ok) begin
                sig_o <= rd_word[B_SIG];
                ref_o <= rd_word[B_REF];
                new_o <= rd_word[B_NEW];
            end
        end
    end

    assert_rd_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !rd_valid_o);

    assert_sig_within_new_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> ((sig_o & ~new_o) == '0));
endmodule

// File: tb/coef_status_mem_tb.sv
`timescale 1ns/1ps
module coef_status_mem_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clear_i = 1'b0, plane_start_i = 1'b0;
    logic       rd_en_i = 1'b0, wr_en_i = 1'b0, wr_tgt_i = 1'b0;
    logic [2:0] rd_stripe_i = '0, wr_stripe_i = '0;
    logic [4:0] rd_col_i = '0, wr_col_i = '0;
    logic [1:0] wr_row_i = '0;
    logic       busy_o, rd_valid_o;
    logic [3:0] sig_o, ref_o, new_o;

    int errs = 0;
    int checks = 0;
    bit m_sig [32][32];
    bit m_ref [32][32];
    bit m_new [32][32];

    always #2.5 clk = ~clk;

    coef_status_mem u_dut (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .plane_start_i(plane_start_i),
        .busy_o(busy_o), .rd_en_i(rd_en_i), .rd_stripe_i(rd_stripe_i),
        .rd_col_i(rd_col_i), .rd_valid_o(rd_valid_o), .sig_o(sig_o),
        .ref_o(ref_o), .new_o(new_o), .wr_en_i(wr_en_i), .wr_tgt_i(wr_tgt_i),
        .wr_stripe_i(wr_stripe_i), .wr_col_i(wr_col_i), .wr_row_i(wr_row_i)
    );

    initial begin
        #(5.0 * 200000);
        errs++;
        checks++;
        $display("FAIL watchdog: run did not finish, act=hung exp=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_word(input int sel, input int s, input int c);
        logic [3:0] w;
        for (int k = 0; k < 4; k++) begin
            if (sel == 0)      w[k] = m_sig[4*s+k][c];
            else if (sel == 1) w[k] = m_ref[4*s+k][c];
            else               w[k] = m_new[4*s+k][c];
        end
        return w;
    endfunction

    task automatic do_read(input int s, input int c, input string req);
        rd_en_i = 1'b1;
        rd_stripe_i = 3'(s);
        rd_col_i = 5'(c);
        @(negedge clk);
        rd_en_i = 1'b0;
        chk(rd_valid_o == 1'b1, {req, " R2 valid"}, 32'(rd_valid_o), 1);
        chk(sig_o == exp_word(0, s, c), {req, " sig word"}, 32'(sig_o), 32'(exp_word(0, s, c)));
        chk(ref_o == exp_word(1, s, c), {req, " ref word"}, 32'(ref_o), 32'(exp_word(1, s, c)));
        chk(new_o == exp_word(2, s, c), {req, " new word"}, 32'(new_o), 32'(exp_word(2, s, c)));
        chk((sig_o & ~new_o) == 4'h0, "R10 sig within new", 32'(sig_o & ~new_o), 0);
    endtask

    task automatic readback(input string req);
        for (int s = 0; s < 8; s++)
            for (int c = 0; c < 32; c++)
                do_read(s, c, req);
    endtask

    task automatic do_write(input int tgt, input int r, input int c);
        wr_en_i = 1'b1;
        wr_tgt_i = tgt[0];
        wr_stripe_i = 3'(r / 4);
        wr_row_i = 2'(r % 4);
        wr_col_i = 5'(c);
        @(negedge clk);
        wr_en_i = 1'b0;
        if (tgt == 0) m_new[r][c] = 1'b1;
        else          m_ref[r][c] = 1'b1;
    endtask

    task automatic model_cmd(input bit pl, input bit cl);
        for (int r = 0; r < 32; r++)
            for (int c = 0; c < 32; c++) begin
                if (cl) begin
                    m_sig[r][c] = 1'b0; m_ref[r][c] = 1'b0; m_new[r][c] = 1'b0;
                end else if (pl) begin
                    m_sig[r][c] = m_new[r][c];
                end
            end
    endtask

    task automatic run_cmd(input bit pl, input bit cl, output int n);
        plane_start_i = pl;
        clear_i = cl;
        @(negedge clk);
        plane_start_i = 1'b0;
        clear_i = 1'b0;
        n = 0;
        while (busy_o && n < 1000) begin
            n++;
            @(negedge clk);
        end
        model_cmd(pl, cl);
    endtask

    initial begin
        int n;
        for (int r = 0; r < 32; r++)
            for (int c = 0; c < 32; c++) begin
                m_sig[r][c] = 0; m_ref[r][c] = 0; m_new[r][c] = 0;
            end
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0, "R1 busy at reset", 32'(busy_o), 0);
        chk(rd_valid_o == 1'b0, "R1 valid at reset", 32'(rd_valid_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 1'b0, "R1 busy after reset", 32'(busy_o), 0);
        readback("R1");

        // Pattern A: update and refinement flags; working array stays clear (R3, R4)
        for (int r = 0; r < 32; r++)
            for (int c = 0; c < 32; c++) begin
                if ((r * 7 + c * 3) % 5 == 0) do_write(0, r, c);
                if ((r + c) % 4 == 1)         do_write(1, r, c);
            end
        readback("R3/R4");

        // R9: read and write of the same word at one edge
        rd_en_i = 1'b1; rd_stripe_i = 3'd0; rd_col_i = 5'd1;
        wr_en_i = 1'b1; wr_tgt_i = 1'b0; wr_stripe_i = 3'd0; wr_col_i = 5'd1; wr_row_i = 2'd0;
        @(negedge clk);
        rd_en_i = 1'b0; wr_en_i = 1'b0;
        chk(new_o[0] == 1'b0, "R9 read sees old flag", 32'(new_o[0]), 0);
        m_new[0][1] = 1'b1;
        do_read(0, 1, "R9 after");
        chk(new_o[0] == 1'b1, "R9 flag now set", 32'(new_o[0]), 1);

        // Plane start: sweep length and copy (R5)
        run_cmd(1'b1, 1'b0, n);
        chk(n == 256, "R5 copy busy cycles", 32'(n), 256);
        readback("R5");

        // Plane start with read, write and clear injected while busy (R6, R8)
        plane_start_i = 1'b1;
        @(negedge clk);
        plane_start_i = 1'b0;
        chk(busy_o == 1'b1, "R5 busy after accept", 32'(busy_o), 1);
        rd_en_i = 1'b1; rd_stripe_i = 3'd0; rd_col_i = 5'd2;
        wr_en_i = 1'b1; wr_tgt_i = 1'b0; wr_stripe_i = 3'd0; wr_col_i = 5'd2; wr_row_i = 2'd0;
        clear_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0; wr_en_i = 1'b0; clear_i = 1'b0;
        chk(rd_valid_o == 1'b0, "R6 read blocked when busy", 32'(rd_valid_o), 0);
        n = 1;
        while (busy_o && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk(n == 256, "R8 clear ignored while busy", 32'(n), 256);
        model_cmd(1'b1, 1'b0);
        readback("R6/R8");

        // Pattern B: more flags; working array unchanged until next plane (R3, R4)
        for (int r = 0; r < 32; r++)
            for (int c = 0; c < 32; c++) begin
                if ((r + 2 * c) % 7 == 3)        do_write(0, r, c);
                if (c % 3 == 0 && r % 2 == 0)    do_write(1, r, c);
            end
        readback("R3/R4");

        // Clear and plane start together: clear wins (R7, R8)
        run_cmd(1'b1, 1'b1, n);
        chk(n == 256, "R7 clear busy cycles", 32'(n), 256);
        readback("R7/R8");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule